// File: doc/BRIEF.md
# Weighted Pseudo-Random Pattern Generator

This block feeds a circuit under test with pseudo-random stimulus whose per-bit chance of being 1 is programmable rather than fixed at one half. A 32-bit maximal-length shift register provides equiprobable bits. Every output bit owns a weighting cell. The cell takes four LFSR taps that no other output bit uses, ANDs one, two, three or four of them, and optionally complements the result. This yields the probabilities 1/2, 1/4, 3/4, 1/8, 7/8, 1/16 and 15/16.

Three weight sets are held in a small register bank. Each set holds a 3-bit code per output bit. A set index chooses which set shapes the pattern on every step. The bank can only be rewritten while the block is idle, so a set cannot change while patterns are being produced.

A two-state controller tracks activity. In IDLE the generator is frozen and accepts configuration writes. The transition IDLE→RUN is taken on a clock edge with `run_en` high. In RUN every edge with `run_en` high advances the generator. The transition RUN→IDLE is taken on an edge with `run_en` low. Each state holds itself otherwise (IDLE→IDLE while `run_en` is low, RUN→RUN while it is high).

Top module: `weighted_pattern_gen`

## Requirements
- R1: After the asynchronous active-low reset, `pattern` is all zeros, the LFSR holds the SEED parameter (default 32'h1D872B41), every weight code in every set is 3'b000, and the controller is in IDLE.
- R2: On each clock edge with `run_en` high, the LFSR state s becomes {s[30:0], s[31]^s[21]^s[1]^s[0]}. The LFSR state is never all zeros.
- R3: Output bit i draws on LFSR bits i, i+8, i+16 and i+24 of the state held before the step, taken in that order as taps 0 to 3.
- R4: Bits [2:1] of a bit's weight code select the AND depth: 00 passes tap 0 (p=1/2), 01 ANDs taps 0–1 (p=1/4), 10 ANDs taps 0–2 (p=1/8), 11 ANDs taps 0–3 (p=1/16).
- R5: Bit [0] of a weight code complements the AND result, giving p=1/2, 3/4, 7/8 or 15/16.
- R6: On an enabled edge, `pattern` takes the weighted value computed with the set named by `set_idx`. An index at or above the set count (3) selects set 0.
- R7: On an edge with `run_en` low, neither the LFSR nor `pattern` changes.
- R8: A write with `cfg_we` high stores `cfg_word` into set `cfg_set` only when the controller is in IDLE and `run_en` is low. In `cfg_word`, bit i's code sits at [3i+2:3i]. Writes in RUN, including on the first edge after `run_en` falls, are ignored, and so are writes to an out-of-range set.
- R9: The controller moves IDLE→RUN on an edge with `run_en` high and RUN→IDLE on an edge with `run_en` low.
- R10: Over 4096 enabled steps, a bit coded 3'b110 is 1 in about 1/16 of patterns, a bit coded 3'b111 in about 15/16, and a bit coded 3'b010 in about 1/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Advance the generator on this edge; low freezes it |
| set_idx | input | 2 | Weight set used for the pattern |
| cfg_we | input | 1 | Weight-set write strobe (honoured in IDLE only) |
| cfg_set | input | 2 | Weight set being written |
| cfg_word | input | 24 | Eight 3-bit codes {depth[1:0], invert}, bit i at [3i+2:3i] |
| pattern | output | 8 | Registered weighted test pattern |

## Verification
The bench programs one set so that bit i carries code i. A single run therefore covers all eight depth/invert combinations, and a wrong tap order or a swapped depth field shows up as miscompares confined to particular bits. A write issued on the first edge after `run_en` falls must be dropped. A design that keys acceptance on `run_en` alone instead of on the controller state would store that write, and the later patterns drawn from set 0 would be wrong. Out-of-range set indices must fall back to set 0, so a design that reads past the bank returns unknown or wrong patterns. Freeze cycles check that `pattern` holds, and the first pattern after a freeze checks that the LFSR did not move during it. A long run with fixed codes measures the ones rate of three bits against the 1/16, 15/16 and 1/4 targets.

// File: rtl/wprpg_pkg.sv
package wprpg_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // per-bit weight code: AND depth in two bits, then the invert flag
    typedef struct packed {
        logic [1:0] depth;
        logic       flip;
    } wcode_t;

    localparam int CODE_W = 3;
    localparam int TAPS   = 4;

endpackage

// File: rtl/wprpg_lfsr.sv
module wprpg_lfsr #(
    parameter int             LEN  = 32,
    parameter logic [LEN-1:0] MASK = 32'h8020_0003,
    parameter logic [LEN-1:0] SEED = 32'h1D87_2B41
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    output logic [LEN-1:0] state
);

    logic [LEN-1:0] st_q;
    logic           fb;

    always_comb begin
        fb = ^(st_q & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEED;
        end else if (step) begin
            st_q <= {st_q[LEN-2:0], fb};
        end
    end

    assign state = st_q;

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);

endmodule

// File: rtl/wprpg_cell.sv
module wprpg_cell
    import wprpg_pkg::*;
(
    input  logic [TAPS-1:0] taps,
    input  wcode_t          code,
    output logic            bit_o
);

    logic prod;

    always_comb begin
        unique case (code.depth)
            2'b00: prod = taps[0];
            2'b01: prod = taps[0] & taps[1];
            2'b10: prod = &taps[2:0];
            2'b11: prod = &taps;
        endcase
        bit_o = prod ^ code.flip;
    end

endmodule

// File: rtl/wprpg_cfg.sv
module wprpg_cfg
    import wprpg_pkg::*;
#(
    parameter int W     = 8,
    parameter int NSETS = 3,
    parameter int SET_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  run_state_t          state,
    input  logic                run_en,
    input  logic                we,
    input  logic [SET_W-1:0]    wset,
    input  logic [CODE_W*W-1:0] wword,
    input  logic [SET_W-1:0]    rset,
    output logic [CODE_W*W-1:0] rword
);

    logic [CODE_W*W-1:0] bank [NSETS];
    logic                accept;

    always_comb begin
        accept = we && !run_en && (state == ST_IDLE) && (int'(wset) < NSETS);
        rword  = (int'(rset) < NSETS) ? bank[rset] : bank[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                bank[s] <= '0;
            end
        end else if (accept) begin
            bank[wset] <= wword;
        end
    end

    for (genvar s = 0; s < NSETS; s++) begin : g_hold
        // R8
        cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_RUN || run_en) |=> $stable(bank[s]));
    end

endmodule

// File: rtl/weighted_pattern_gen.sv
module weighted_pattern_gen
    import wprpg_pkg::*;
#(
    parameter int             W     = 8,
    parameter int             LEN   = 32,
    parameter int             NSETS = 3,
    parameter logic [LEN-1:0] MASK  = 32'h8020_0003,
    parameter logic [LEN-1:0] SEED  = 32'h1D87_2B41
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic [1:0]          set_idx,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_set,
    input  logic [3*W-1:0]      cfg_word,
    output logic [W-1:0]        pattern
);

    localparam int SET_W  = 2;
    localparam int STRIDE = LEN / TAPS;

    run_state_t           state_q, state_d;
    logic                 step;
    logic [LEN-1:0]       lfsr;
    logic [CODE_W*W-1:0]  codes;
    logic [W-1:0]         weighted;
    logic [W-1:0]         pat_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_en) begin
                    state_d = ST_RUN;
                    step    = 1'b1;
                end
            end
            ST_RUN: begin
                if (run_en) begin
                    step    = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    wprpg_lfsr #(.LEN(LEN), .MASK(MASK), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .state (lfsr)
    );

    wprpg_cfg #(.W(W), .NSETS(NSETS), .SET_W(SET_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state_q),
        .run_en (run_en),
        .we     (cfg_we),
        .wset   (cfg_set),
        .wword  (cfg_word),
        .rset   (set_idx),
        .rword  (codes)
    );

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic [TAPS-1:0] taps;
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            assign taps[k] = lfsr[i + k*STRIDE];
        end
        wprpg_cell u_cell (
            .taps  (taps),
            .code  (wcode_t'(codes[CODE_W*i +: CODE_W])),
            .bit_o (weighted[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= '0;
        end else if (step) begin
            pat_q <= weighted;
        end
    end

    assign pattern = pat_q;

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(pattern) && $stable(lfsr)));

    // R9
    idle_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (state_q == ST_RUN));

    // R9
    run_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == ST_IDLE));

endmodule

// File: tb/tb_weighted_pattern_gen.sv
module tb_weighted_pattern_gen;

    localparam int          W     = 8;
    localparam int          LEN   = 32;
    localparam int          NSETS = 3;
    localparam logic [31:0] SEED  = 32'h1D87_2B41;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           run_en = 1'b0;
    logic [1:0]     set_idx = '0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_set = '0;
    logic [3*W-1:0] cfg_word = '0;
    logic [W-1:0]   pattern;

    always #10 clk = ~clk;

    weighted_pattern_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .set_idx  (set_idx),
        .cfg_we   (cfg_we),
        .cfg_set  (cfg_set),
        .cfg_word (cfg_word),
        .pattern  (pattern)
    );

    // reference model state
    logic [31:0]    m_lfsr;
    logic [3*W-1:0] m_bank [NSETS];
    logic           m_run;
    logic [W-1:0]   m_pat;

    logic [W-1:0]   exp_q [$];
    string          tag_q [$];
    int             n_chk = 0;
    int             n_bad = 0;
    bit             stat_on = 1'b0;
    int             ones2 = 0, ones6 = 0, ones7 = 0;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [W-1:0] weigh(input logic [31:0] s, input logic [3*W-1:0] wd);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            logic [2:0] c;
            logic       p;
            c = wd[3*i +: 3];
            p = 1'b1;
            for (int k = 0; k <= int'(c[2:1]); k++) p = p & s[i + 8*k];
            r[i] = p ^ c[0];
        end
        return r;
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // driver: one cycle of stimulus, expected pattern pushed to the scoreboard
    task automatic drive(input logic en, input logic [1:0] sel, input logic we,
                         input logic [1:0] ws, input logic [3*W-1:0] wd, input string tag);
        @(negedge clk);
        run_en = en; set_idx = sel; cfg_we = we; cfg_set = ws; cfg_word = wd;
        if (en) begin
            int rs;
            rs = (int'(sel) < NSETS) ? int'(sel) : 0;
            m_pat  = weigh(m_lfsr, m_bank[rs]);
            m_lfsr = lfsr_next(m_lfsr);
        end else if (we && !m_run && int'(ws) < NSETS) begin
            m_bank[ws] = wd;
        end
        m_run = en;
        exp_q.push_back(m_pat);
        tag_q.push_back(tag);
    endtask

    task automatic run(input int n, input logic [1:0] sel, input string tag);
        for (int c = 0; c < n; c++) drive(1'b1, sel, 1'b0, 2'd0, '0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int c = 0; c < n; c++) drive(1'b0, 2'd0, 1'b0, 2'd0, '0, tag);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [W-1:0] e;
                string        t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (pattern !== e) begin
                    n_bad++;
                    $display("FAIL %s: pattern=%h expected=%h", t, pattern, e);
                end
                if (stat_on) begin
                    ones2 += int'(pattern[2]);
                    ones6 += int'(pattern[6]);
                    ones7 += int'(pattern[7]);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): run did not finish, cycles=200000 expected fewer");
        summary();
        $finish;
    end

    initial begin
        logic [3*W-1:0] up, down;
        for (int i = 0; i < W; i++) begin
            up[3*i +: 3]   = 3'(i);
            down[3*i +: 3] = 3'(W - 1 - i);
        end
        m_lfsr = SEED;
        for (int s = 0; s < NSETS; s++) m_bank[s] = '0;
        m_run = 1'b0;
        m_pat = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset value of the pattern
        check(pattern === '0, "R1 reset pattern", int'(pattern), 0);

        // R1 R2 R3: default codes pass tap 0 (LFSR bit i) from the seeded LFSR
        run(20, 2'd0, "R3 default set raw taps");
        // R7: freeze holds pattern; next run shows the LFSR did not move
        idle(3, "R7 freeze");
        run(4, 2'd0, "R7 resume after freeze");
        idle(1, "R9 enter idle");

        // R8: legal writes while idle
        drive(1'b0, 2'd0, 1'b1, 2'd1, up,   "R8 write set1");
        drive(1'b0, 2'd0, 1'b1, 2'd2, down, "R8 write set2");
        drive(1'b0, 2'd0, 1'b1, 2'd3, {3*W{1'b1}}, "R8 write out-of-range set");

        // R4 R5: bit i carries code i in set1, code 7-i in set2
        run(40, 2'd1, "R4 R5 set1 codes");
        run(40, 2'd2, "R4 R5 set2 codes");
        // R6: out-of-range index falls back to set 0
        run(10, 2'd3, "R6 index 3 uses set0");
        run(4, 2'd1, "R6 switch back to set1");

        // R8: writes during RUN and on the first idle edge are dropped
        drive(1'b1, 2'd0, 1'b1, 2'd0, {3*W{1'b1}}, "R8 write while running");
        drive(1'b0, 2'd0, 1'b1, 2'd0, {3*W{1'b1}}, "R8 write on first idle edge");
        idle(1, "R9 settle idle");
        run(12, 2'd0, "R8 set0 unchanged");
        idle(1, "R9 enter idle again");
        drive(1'b0, 2'd0, 1'b1, 2'd0, up ^ {3*W{1'b1}}, "R8 write set0 idle");
        run(12, 2'd0, "R8 set0 rewritten");
        run(12, 2'd3, "R6 index 3 sees new set0");
        idle(1, "R7 pause");

        // R10: long run with set1 for ones-rate measurement
        stat_on = 1'b1;
        run(4096, 2'd1, "R10 long run");
        idle(1, "R10 end");
        stat_on = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check(ones6 >= 150 && ones6 <= 370, "R10 bit6 p=1/16", ones6, 256);
        check(ones7 >= 3720 && ones7 <= 3950, "R10 bit7 p=15/16", ones7, 3840);
        check(ones2 >= 850 && ones2 <= 1200, "R10 bit2 p=1/4", ones2, 1024);

        summary();
        $finish;
    end

endmodule